// File: doc/BRIEF.md
# ALU with flag generation

A combinational 32-bit arithmetic and logic unit for a small RISC datapath, with a registered set of condition flags beside it. Each cycle it takes a first operand, a second operand that is either a register value or a 16-bit constant, a 3-bit operation code and a placement/shift-kind select. From these it produces a 32-bit result and the next zero, negative, overflow and carry flags. The add-with-carry and subtract-with-borrow operations take their carry-in from the stored carry flag.

When the constant is used, the unit builds the full-width second operand itself. For the non-shift operations the select bit puts the constant in the upper or lower half, and the other half is filled with zeros, or with ones for AND. For the shift operation the constant is sign-extended, and the select bit picks a logical or an arithmetic shift. The signed value of the second operand gives both the direction and the distance of a shift: positive values shift left and negative values shift right. The flag register loads the next flags only on a cycle where the update enable is high.

Top module: `alu_flags_unit`

## Requirements
- R1: op_i selects the operation: 000 add, 001 add-with-carry, 010 subtract, 011 subtract-with-borrow, 100 AND, 101 OR, 110 XOR, 111 shift. Subtract computes a + ~b + 1. Add computes a + b.
- R2: AND, OR and XOR return the bitwise result of the first operand and the second operand.
- R3: With use_imm_i=1 and a non-shift op, place_i=1 puts imm_i in bits 31:16 and place_i=0 puts it in bits 15:0. The other half is 0x0000, or 0xFFFF when the op is AND. With use_imm_i=0 the second operand is opb_i.
- R4: With use_imm_i=1 and the shift op, imm_i is sign-extended to 32 bits. For every shift, place_i=0 selects a logical right shift and place_i=1 an arithmetic right shift.
- R5: The shift distance is the low 6 bits of the second operand read as a signed number. Values 1 to 31 shift left, values -1 to -31 shift right by the magnitude, and 0 returns the first operand unchanged.
- R6: The next Z flag (next_flags_o bit 3) is 1 when the result is zero. The next N flag (bit 2) equals result bit 31.
- R7: The next V flag (bit 1) is 1 for the four arithmetic ops when both adder inputs (a, and b or ~b) have the same sign and the result sign differs from it. V is 0 for every other op.
- R8: The next C flag (bit 0) is the adder carry out of bit 31 for the arithmetic ops. For a left shift it is the last bit shifted out. For right shifts, a zero shift and the logic ops it is 0.
- R9: Add-with-carry computes a + b + C, and subtract-with-borrow computes a + ~b + C, where C is the stored carry flag (flags_o bit 0).
- R10: flags_o loads next_flags_o at a rising clock edge where flag_we_i=1, and otherwise keeps its value.
- R11: A synchronous active-high rst clears flags_o to 0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the flag register |
| op_i | input | 3 | Operation code |
| use_imm_i | input | 1 | 1: second operand comes from imm_i, 0: from opb_i |
| place_i | input | 1 | Constant half select for non-shift ops; right-shift kind (1 arithmetic) for shift |
| imm_i | input | 16 | 16-bit constant |
| opa_i | input | 32 | First operand |
| opb_i | input | 32 | Register second operand |
| flag_we_i | input | 1 | Flag register update enable |
| result_o | output | 32 | Operation result |
| next_flags_o | output | 4 | Next flags {Z,N,V,C} |
| flags_o | output | 4 | Stored flags {Z,N,V,C} |

## Verification
The vector table runs the adder on operands that produce signed overflow, an unsigned carry, an exact zero and a negative difference. These cases separate the V rule from the C rule and show that subtract inverts the second operand. Constants are applied in both halves under AND and under OR/ADD, which shows the ones fill apart from the zero fill. Shifts are tried at distances 0, 1, 4, 31, -4 and -31 on operands with bit 31 set, from both the constant and the register. This shows direction, magnitude, logical versus arithmetic fill, and which discarded bit becomes the carry. Directed steps then load the carry flag and repeat the carry-in ops with it set and clear, and they show the flag register holding when the enable is low.

// File: rtl/alu_pkg.sv
package alu_pkg;

    parameter int unsigned XLEN  = 32;
    parameter int unsigned KLEN  = 16;

    typedef enum logic [2:0] {
        OP_ADD  = 3'b000,
        OP_ADDC = 3'b001,
        OP_SUB  = 3'b010,
        OP_SUBB = 3'b011,
        OP_AND  = 3'b100,
        OP_OR   = 3'b101,
        OP_XOR  = 3'b110,
        OP_SHF  = 3'b111
    } alu_op_e;

    typedef struct packed {
        logic z;
        logic n;
        logic v;
        logic c;
    } flags_t;

    function automatic logic is_arith(alu_op_e op);
        return (op == OP_ADD) || (op == OP_ADDC) || (op == OP_SUB) || (op == OP_SUBB);
    endfunction

    function automatic logic is_logic(alu_op_e op);
        return (op == OP_AND) || (op == OP_OR) || (op == OP_XOR);
    endfunction

endpackage

// File: rtl/alu_imm_gen.sv
module alu_imm_gen
    import alu_pkg::*;
#(
    parameter int unsigned DATA_W = XLEN,
    parameter int unsigned IMM_W  = KLEN
) (
    input  alu_op_e            op,
    input  logic               place,
    input  logic [IMM_W-1:0]   k,
    output logic [DATA_W-1:0]  imm_o
);
    localparam int unsigned PAD_W = DATA_W - IMM_W;

    logic             fill_bit;
    logic [PAD_W-1:0] pad;

    assign fill_bit = (op == OP_AND);
    assign pad      = {PAD_W{fill_bit}};

    always_comb begin
        if (op == OP_SHF) begin
            imm_o = {{PAD_W{k[IMM_W-1]}}, k};
        end else if (place) begin
            imm_o = {k, pad};
        end else begin
            imm_o = {pad, k};
        end
    end
endmodule

// File: rtl/alu_adder.sv
module alu_adder #(
    parameter int unsigned DATA_W = 32
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              sub_i,
    input  logic              use_c_i,
    input  logic              c_flag_i,
    output logic [DATA_W-1:0] sum_o,
    output logic              cout_o,
    output logic              ovf_o
);
    localparam int unsigned MSB = DATA_W - 1;

    logic [DATA_W-1:0] b_in;
    logic              cin;
    logic [DATA_W:0]   wide;

    assign b_in   = sub_i ? ~b : b;
    assign cin    = use_c_i ? c_flag_i : sub_i;
    assign wide   = {1'b0, a} + {1'b0, b_in} + {{DATA_W{1'b0}}, cin};
    assign sum_o  = wide[DATA_W-1:0];
    assign cout_o = wide[DATA_W];
    assign ovf_o  = (a[MSB] == b_in[MSB]) && (wide[MSB] != a[MSB]);
endmodule

// File: rtl/alu_shifter.sv
module alu_shifter #(
    parameter int unsigned DATA_W = 32,
    localparam int unsigned SH_W  = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] a,
    input  logic [SH_W:0]     amt,
    input  logic              arith,
    output logic [DATA_W-1:0] res_o,
    output logic              cout_o
);
    logic            go_right;
    logic [SH_W:0]   neg_amt;
    logic [SH_W-1:0] left_mag;
    logic [SH_W-1:0] right_mag;
    logic [DATA_W:0] left_ext;

    assign go_right  = amt[SH_W];
    assign neg_amt   = ~amt + {{SH_W{1'b0}}, 1'b1};
    assign left_mag  = amt[SH_W-1:0];
    assign right_mag = neg_amt[SH_W-1:0];
    assign left_ext  = {1'b0, a} << left_mag;

    always_comb begin
        if (go_right) begin
            cout_o = 1'b0;
            if (arith) begin
                res_o = $signed(a) >>> right_mag;
            end else begin
                res_o = a >> right_mag;
            end
        end else begin
            res_o  = left_ext[DATA_W-1:0];
            cout_o = left_ext[DATA_W];
        end
    end
endmodule

// File: rtl/alu_flag_reg.sv
module alu_flag_reg
    import alu_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   we,
    input  flags_t d,
    output flags_t q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (we) begin
            q <= d;
        end
    end

    // R10: no enable, no change
    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(q));

    // R10: enabled edge captures the presented flags
    p_load_r10: assert property (@(posedge clk) disable iff (rst)
        we |=> (q == $past(d)));

    // R11: flags are clear in the first cycle out of reset
    p_reset_r11: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (q == '0));
endmodule

// File: rtl/alu_flags_unit.sv
module alu_flags_unit
    import alu_pkg::*;
#(
    parameter int unsigned DATA_W = XLEN,
    parameter int unsigned IMM_W  = KLEN,
    localparam int unsigned SH_W  = $clog2(DATA_W),
    localparam int unsigned MSB   = DATA_W - 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        op_i,
    input  logic              use_imm_i,
    input  logic              place_i,
    input  logic [IMM_W-1:0]  imm_i,
    input  logic [DATA_W-1:0] opa_i,
    input  logic [DATA_W-1:0] opb_i,
    input  logic              flag_we_i,
    output logic [DATA_W-1:0] result_o,
    output logic [3:0]        next_flags_o,
    output logic [3:0]        flags_o
);
    alu_op_e           op;
    logic [DATA_W-1:0] imm_full;
    logic [DATA_W-1:0] b_eff;
    logic [DATA_W-1:0] add_res;
    logic              add_c;
    logic              add_v;
    logic [DATA_W-1:0] shf_res;
    logic              shf_c;
    flags_t            cur_flags;
    flags_t            nxt;
    logic [DATA_W-1:0] res;

    assign op    = alu_op_e'(op_i);
    assign b_eff = use_imm_i ? imm_full : opb_i;

    alu_imm_gen #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_imm (
        .op    (op),
        .place (place_i),
        .k     (imm_i),
        .imm_o (imm_full)
    );

    alu_adder #(.DATA_W(DATA_W)) u_add (
        .a        (opa_i),
        .b        (b_eff),
        .sub_i    (op_i[1]),
        .use_c_i  (op_i[0]),
        .c_flag_i (cur_flags.c),
        .sum_o    (add_res),
        .cout_o   (add_c),
        .ovf_o    (add_v)
    );

    alu_shifter #(.DATA_W(DATA_W)) u_shf (
        .a      (opa_i),
        .amt    (b_eff[SH_W:0]),
        .arith  (place_i),
        .res_o  (shf_res),
        .cout_o (shf_c)
    );

    always_comb begin
        case (op)
            OP_AND:  res = opa_i & b_eff;
            OP_OR:   res = opa_i | b_eff;
            OP_XOR:  res = opa_i ^ b_eff;
            OP_SHF:  res = shf_res;
            default: res = add_res;
        endcase
    end

    always_comb begin
        nxt.z = (res == '0);
        nxt.n = res[MSB];
        nxt.v = is_arith(op) ? add_v : 1'b0;
        if (is_arith(op)) begin
            nxt.c = add_c;
        end else if (op == OP_SHF) begin
            nxt.c = shf_c;
        end else begin
            nxt.c = 1'b0;
        end
    end

    alu_flag_reg u_flags (
        .clk (clk),
        .rst (rst),
        .we  (flag_we_i),
        .d   (nxt),
        .q   (cur_flags)
    );

    assign result_o     = res;
    assign next_flags_o = nxt;
    assign flags_o      = cur_flags;

    // R7, R8: logic ops never raise overflow or carry
    p_logic_clear_r7: assert property (@(posedge clk) disable iff (rst)
        is_logic(op) |-> (!next_flags_o[1] && !next_flags_o[0]));

    // R7: plain add of opposite-sign operands cannot overflow
    p_mixed_sign_r7: assert property (@(posedge clk) disable iff (rst)
        (op == OP_ADD && opa_i[MSB] != b_eff[MSB]) |-> !next_flags_o[1]);

    // R5, R8: zero shift distance passes the operand and clears carry
    p_shift_zero_r5: assert property (@(posedge clk) disable iff (rst)
        (op == OP_SHF && b_eff[SH_W:0] == '0) |-> (result_o == opa_i && !next_flags_o[0]));

    // R8: right shifts clear carry
    p_rshift_noc_r8: assert property (@(posedge clk) disable iff (rst)
        (op == OP_SHF && b_eff[SH_W]) |-> !next_flags_o[0]);

    // R3: AND constant in the low half gets an all-ones upper half
    p_and_fill_r3: assert property (@(posedge clk) disable iff (rst)
        (use_imm_i && op == OP_AND && !place_i) |-> (b_eff[MSB:IMM_W] == '1));
endmodule

// File: tb/alu_flags_unit_tb_top.sv
module alu_flags_unit_tb_top;

    typedef struct packed {
        logic [3:0]  req;
        logic [2:0]  op;
        logic        imm;
        logic        plc;
        logic [31:0] a;
        logic [31:0] b;
        logic [15:0] k;
        logic [31:0] res;
        logic [3:0]  fl;
    } vec_t;

    localparam int NVEC = 23;

    // flags column is {Z,N,V,C}; stored carry is 0 throughout the table
    localparam vec_t VECS [NVEC] = '{
        '{4'd1,  3'b000, 1'b0, 1'b0, 32'h00000001, 32'h00000002, 16'h0000, 32'h00000003, 4'b0000}, // R1
        '{4'd7,  3'b000, 1'b0, 1'b0, 32'h7FFFFFFF, 32'h00000001, 16'h0000, 32'h80000000, 4'b0110}, // R7
        '{4'd8,  3'b000, 1'b0, 1'b0, 32'hFFFFFFFF, 32'h00000001, 16'h0000, 32'h00000000, 4'b1001}, // R8 R6
        '{4'd1,  3'b010, 1'b0, 1'b0, 32'h00000005, 32'h00000005, 16'h0000, 32'h00000000, 4'b1001}, // R1
        '{4'd6,  3'b010, 1'b0, 1'b0, 32'h00000003, 32'h00000005, 16'h0000, 32'hFFFFFFFE, 4'b0100}, // R6
        '{4'd9,  3'b011, 1'b0, 1'b0, 32'h0000000A, 32'h00000003, 16'h0000, 32'h00000006, 4'b0001}, // R9
        '{4'd9,  3'b001, 1'b0, 1'b0, 32'h00000001, 32'h00000001, 16'h0000, 32'h00000002, 4'b0000}, // R9
        '{4'd2,  3'b100, 1'b0, 1'b0, 32'hF0F0F0F0, 32'hFF00FF00, 16'h0000, 32'hF000F000, 4'b0100}, // R2
        '{4'd2,  3'b101, 1'b0, 1'b0, 32'h00000000, 32'h00000000, 16'h0000, 32'h00000000, 4'b1000}, // R2
        '{4'd2,  3'b110, 1'b0, 1'b0, 32'hFFFF0000, 32'h0000FFFF, 16'h0000, 32'hFFFFFFFF, 4'b0100}, // R2
        '{4'd3,  3'b100, 1'b1, 1'b0, 32'h12345678, 32'h00000000, 16'h00FF, 32'h12340078, 4'b0000}, // R3
        '{4'd3,  3'b100, 1'b1, 1'b1, 32'h12345678, 32'h00000000, 16'h00FF, 32'h00345678, 4'b0000}, // R3
        '{4'd3,  3'b101, 1'b1, 1'b1, 32'h00000000, 32'hFFFFFFFF, 16'hABCD, 32'hABCD0000, 4'b0100}, // R3
        '{4'd3,  3'b000, 1'b1, 1'b0, 32'h00000010, 32'h00000000, 16'hFFFF, 32'h0001000F, 4'b0000}, // R3
        '{4'd5,  3'b111, 1'b1, 1'b0, 32'h00000001, 32'h00000000, 16'h0004, 32'h00000010, 4'b0000}, // R5
        '{4'd8,  3'b111, 1'b1, 1'b0, 32'h80000001, 32'h00000000, 16'h0001, 32'h00000002, 4'b0001}, // R8
        '{4'd8,  3'b111, 1'b1, 1'b0, 32'h00000003, 32'h00000000, 16'h001F, 32'h80000000, 4'b0101}, // R8
        '{4'd4,  3'b111, 1'b1, 1'b0, 32'h80000000, 32'h00000000, 16'hFFFC, 32'h08000000, 4'b0000}, // R4
        '{4'd4,  3'b111, 1'b1, 1'b1, 32'h80000000, 32'h00000000, 16'hFFFC, 32'hF8000000, 4'b0100}, // R4
        '{4'd5,  3'b111, 1'b0, 1'b1, 32'h80000000, 32'hFFFFFFE1, 16'h0000, 32'hFFFFFFFF, 4'b0100}, // R5
        '{4'd5,  3'b111, 1'b0, 1'b0, 32'hDEADBEEF, 32'h00000000, 16'h0000, 32'hDEADBEEF, 4'b0100}, // R5
        '{4'd8,  3'b111, 1'b0, 1'b0, 32'hF0000001, 32'h00000004, 16'h0000, 32'h00000010, 4'b0001}, // R8
        '{4'd7,  3'b010, 1'b0, 1'b0, 32'h80000000, 32'h00000001, 16'h0000, 32'h7FFFFFFF, 4'b0011}  // R7
    };

    logic        clk = 1'b0;
    logic        rst;
    logic [2:0]  op_i;
    logic        use_imm_i;
    logic        place_i;
    logic [15:0] imm_i;
    logic [31:0] opa_i;
    logic [31:0] opb_i;
    logic        flag_we_i;
    logic [31:0] result_o;
    logic [3:0]  next_flags_o;
    logic [3:0]  flags_o;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    alu_flags_unit dut_i (
        .clk          (clk),
        .rst          (rst),
        .op_i         (op_i),
        .use_imm_i    (use_imm_i),
        .place_i      (place_i),
        .imm_i        (imm_i),
        .opa_i        (opa_i),
        .opb_i        (opb_i),
        .flag_we_i    (flag_we_i),
        .result_o     (result_o),
        .next_flags_o (next_flags_o),
        .flags_o      (flags_o)
    );

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic drive(input logic [2:0] op, input logic imm, input logic plc,
                         input logic [31:0] a, input logic [31:0] b, input logic [15:0] k);
        op_i      = op;
        use_imm_i = imm;
        place_i   = plc;
        opa_i     = a;
        opb_i     = b;
        imm_i     = k;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog (all requirements): actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst       = 1'b1;
        flag_we_i = 1'b0;
        drive(3'b000, 1'b0, 1'b0, 32'h0, 32'h0, 16'h0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check("R11", "flags after reset", {28'h0, flags_o}, 32'h0);

        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            drive(VECS[i].op, VECS[i].imm, VECS[i].plc, VECS[i].a, VECS[i].b, VECS[i].k);
            #1;
            check($sformatf("R%0d", VECS[i].req), $sformatf("vector %0d result", i),
                  result_o, VECS[i].res);
            check($sformatf("R%0d", VECS[i].req), $sformatf("vector %0d flags", i),
                  {28'h0, next_flags_o}, {28'h0, VECS[i].fl});
        end

        // R10: load flags from FFFFFFFF+1 (Z=1, C=1)
        @(negedge clk);
        drive(3'b000, 1'b0, 1'b0, 32'hFFFFFFFF, 32'h00000001, 16'h0);
        flag_we_i = 1'b1;
        @(posedge clk);
        #1;
        check("R10", "flags loaded", {28'h0, flags_o}, 32'h9);

        // R10: enable low, different next flags, register holds
        @(negedge clk);
        flag_we_i = 1'b0;
        drive(3'b010, 1'b0, 1'b0, 32'h3, 32'h5, 16'h0);
        @(posedge clk);
        #1;
        check("R10", "flags held", {28'h0, flags_o}, 32'h9);

        // R9: stored carry now 1
        @(negedge clk);
        drive(3'b001, 1'b0, 1'b0, 32'h1, 32'h1, 16'h0);
        #1;
        check("R9", "addc with C=1", result_o, 32'h3);
        drive(3'b011, 1'b0, 1'b0, 32'hA, 32'h3, 16'h0);
        #1;
        check("R9", "subb with C=1", result_o, 32'h7);
        check("R9", "subb with C=1 flags", {28'h0, next_flags_o}, 32'h1);
        drive(3'b000, 1'b0, 1'b0, 32'h1, 32'h1, 16'h0);
        #1;
        check("R1", "plain add ignores C", result_o, 32'h2);

        // R11: reset in the middle of operation
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        check("R11", "flags after second reset", {28'h0, flags_o}, 32'h0);
        @(negedge clk);
        rst = 1'b0;

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule